// File: doc/BRIEF.md
# Vectored Interrupt Pending Controller

This block gathers interrupt requests from up to 32 on-chip sources into one pending register, masks them, picks a single winner by a fixed priority order and drives one interrupt request line to the processor core. The core reads and writes four 32-bit registers through a plain synchronous port: a control word, the pending word, the mask word and the vector word. Register reads are combinational and writes take effect at the clock edge.

To service an interrupt the core writes 1 to bit 0 of the vector word. At that edge the controller records the 5-bit index of the current winner, and the core can read that index from the vector word in the next cycle. Sources that own a private event register keep their pending bit until they drop their request. For every other source the acknowledge clears the pending bit. A control bit selects between two priority orders. In grouped order the three communication sources (indices 1, 2 and 3) sit at the top. In spread order they are placed at regular intervals through the table. The controller only takes up a change of this bit while nothing is pending.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: While control bit 0 (enable) is 0, `irq_o` stays low whatever is pending. The pending and mask words can still be read and written.
- R3: A latching source s that is high on `src_req[s]` at a clock edge sets pending bit s at that edge. The bit stays set after the source goes low.
- R4: `irq_o` is high exactly when enable is 1 and the AND of the pending word and the mask word (address 2) is nonzero. It rises at the same edge that sets the pending bit.
- R5: A write to address 3 with data bit 0 = 1 is an acknowledge. It loads the winner's index into bits [4:0] of the vector word, and that value is readable after that edge.
- R6: The acknowledge clears the winner's pending bit at the same edge when the winner is a latching source.
- R7: Sources 1, 2, 3, 15, 26, 27 and 28 own event registers. Their pending bit follows the level of the request one edge later, and neither the acknowledge nor a software clear removes it.
- R8: In grouped order (control bit 1 = 0) the lowest unmasked pending index wins.
- R9: In spread order, communication source k (k = 0, 1, 2 for indices 1, 2, 3) takes rank 11·k. Every other source keeps its index order and fills the remaining ranks. The lowest rank wins, so index 5 beats index 2, index 2 beats index 13, and index 3 loses to index 13 but beats index 30.
- R10: The controller takes up control bit 1 only at an edge where no unmasked source is pending. While a source is pending, the order in force does not change.
- R11: An acknowledge with no unmasked source pending loads the error vector 31.
- R12: Indices 4, 12, 18, 23 and 31 are reserved. They read as 0 in the pending and mask words, ignore writes and never raise `irq_o`.
- R13: Writing 1 to a pending-word bit (address 1) clears that bit for a latching source. Writing 0 has no effect, and a source input that is high at the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Interrupt request from each source, index = bit |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 pending, 2 mask, 3 vector |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
A source input sampled at edge N shows up in the pending word and on `irq_o` right after edge N, without any extra cycle. An acknowledge written at edge N has its vector and its pending clear visible after the same edge. The bench drives every input at a falling edge, lets one rising edge pass and samples at the next falling edge, so each result is read half a period after the edge that produces it. A spread-mode change has one edge of latency and is only taken up while the masked pending word is zero, so the bench programs the mode one cycle before it raises any source.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam int NSRC      = 32;
  localparam int IDX_W     = $clog2(NSRC);
  localparam int COMM_BASE = 1;
  localparam int COMM_N    = 3;
  localparam int SPREAD_GAP = 10;

  localparam logic [NSRC-1:0] RSV_DEFAULT = 32'h8084_1010;
  localparam logic [NSRC-1:0] EVT_DEFAULT = 32'h1C00_800E;
  localparam logic [IDX_W-1:0] ERR_VEC    = IDX_W'(NSRC - 1);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PEND = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_VEC  = 2'd3;

  function automatic bit is_comm(int idx);
    return (idx >= COMM_BASE) && (idx < COMM_BASE + COMM_N);
  endfunction

  // Rank of a source in the priority table (0 = highest).
  function automatic int rank_of(int idx, bit spread);
    int p;
    int cnt;
    if (!spread) return idx;
    if (is_comm(idx)) return (idx - COMM_BASE) * (SPREAD_GAP + 1);
    p = (idx < COMM_BASE) ? idx : idx - COMM_N;
    cnt = 0;
    for (int k = 0; k < COMM_N; k++) begin
      if (k * SPREAD_GAP <= p) cnt++;
    end
    return p + cnt;
  endfunction

endpackage

// File: rtl/ivc_pend_bank.sv
module ivc_pend_bank #(
  parameter int NSRC = 32,
  parameter logic [NSRC-1:0] RSV_MAP = '0,
  parameter logic [NSRC-1:0] EVT_MAP = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] ack_clr,
  output logic [NSRC-1:0] pend_q
);

  for (genvar s = 0; s < NSRC; s++) begin : g_bit
    if (RSV_MAP[s]) begin : g_rsv
      assign pend_q[s] = 1'b0;
    end else if (EVT_MAP[s]) begin : g_evt
      logic lvl_q;
      always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= src_req[s];
      end
      assign pend_q[s] = lvl_q;
    end else begin : g_lat
      logic lat_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                       lat_q <= 1'b0;
        else if (src_req[s])              lat_q <= 1'b1;
        else if (sw_clr[s] || ack_clr[s]) lat_q <= 1'b0;
      end
      assign pend_q[s] = lat_q;
    end
  end

endmodule

// File: rtl/ivc_rank_map.sv
module ivc_rank_map #(
  parameter int NSRC = 32,
  parameter bit SPREAD = 1'b0
) (
  input  logic [NSRC-1:0] by_src,
  output logic [NSRC-1:0] by_rank
);

  for (genvar s = 0; s < NSRC; s++) begin : g_map
    assign by_rank[ivc_pkg::rank_of(s, SPREAD)] = by_src[s];
  end

endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int N = 32,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output logic [W-1:0] idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter logic [NSRC-1:0] RSV_MAP = RSV_DEFAULT,
  parameter logic [NSRC-1:0] EVT_MAP = EVT_DEFAULT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_o
);

  localparam logic [NSRC-1:0] LATCH_MAP = ~(RSV_MAP | EVT_MAP);

  logic             ctrl_en, ctrl_spread, spread_q;
  logic [NSRC-1:0]  mask_q, pend_q, masked;
  logic [NSRC-1:0]  sw_clr, ack_clr;
  logic [NSRC-1:0]  rank_grp, rank_spr, rank_sel;
  logic [IDX_W-1:0] vec_q, win_rank, win_idx;
  logic             win_hit, any_pend, ack_fire;

  // Named internal events
  assign ack_fire = bus_we && (bus_addr == A_VEC) && bus_wdata[0];
  assign sw_clr   = (bus_we && bus_addr == A_PEND) ? (bus_wdata & LATCH_MAP) : '0;
  assign masked   = pend_q & mask_q;
  assign any_pend = |masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en     <= 1'b0;
      ctrl_spread <= 1'b0;
      mask_q      <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CTRL) begin
        ctrl_en     <= bus_wdata[0];
        ctrl_spread <= bus_wdata[1];
      end
      if (bus_addr == A_MASK) mask_q <= bus_wdata & ~RSV_MAP;
    end
  end

  // Order is taken up only while nothing is outstanding
  always_ff @(posedge clk) begin
    if (!rst_n)         spread_q <= 1'b0;
    else if (!any_pend) spread_q <= ctrl_spread;
  end

  ivc_pend_bank #(.NSRC(NSRC), .RSV_MAP(RSV_MAP), .EVT_MAP(EVT_MAP)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_req (src_req),
    .sw_clr  (sw_clr),
    .ack_clr (ack_clr),
    .pend_q  (pend_q)
  );

  ivc_rank_map #(.NSRC(NSRC), .SPREAD(1'b0)) u_map_grp (
    .by_src  (masked),
    .by_rank (rank_grp)
  );

  ivc_rank_map #(.NSRC(NSRC), .SPREAD(1'b1)) u_map_spr (
    .by_src  (masked),
    .by_rank (rank_spr)
  );

  assign rank_sel = spread_q ? rank_spr : rank_grp;

  ivc_prio_enc #(.N(NSRC), .W(IDX_W)) u_enc (
    .req (rank_sel),
    .hit (win_hit),
    .idx (win_rank)
  );

  always_comb begin
    win_idx = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (rank_of(s, spread_q) == int'(win_rank)) win_idx = IDX_W'(s);
    end
  end

  always_comb begin
    ack_clr = '0;
    if (ack_fire && win_hit) ack_clr[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        vec_q <= '0;
    else if (ack_fire) vec_q <= win_hit ? win_idx : ERR_VEC;
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = {{(NSRC-2){1'b0}}, ctrl_spread, ctrl_en};
      A_PEND:  bus_rdata = pend_q;
      A_MASK:  bus_rdata = mask_q;
      default: bus_rdata = {{(NSRC-IDX_W){1'b0}}, vec_q};
    endcase
  end

  assign irq_o = ctrl_en & any_pend;

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter logic [NSRC-1:0] RSV_MAP = RSV_DEFAULT,
  parameter logic [NSRC-1:0] EVT_MAP = EVT_DEFAULT
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_req,
  input logic             irq_o,
  input logic [NSRC-1:0]  pend_q,
  input logic [NSRC-1:0]  mask_q,
  input logic             ctrl_en,
  input logic             spread_q,
  input logic             ack_fire,
  input logic             win_hit,
  input logic [IDX_W-1:0] win_idx,
  input logic [IDX_W-1:0] vec_q,
  input logic             any_pend
);

  localparam logic [NSRC-1:0] LATCH_MAP = ~(RSV_MAP | EVT_MAP);

  a_r2_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !irq_o);

  a_r3_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_req & LATCH_MAP) != '0) |=>
      ((pend_q & $past(src_req & LATCH_MAP)) == $past(src_req & LATCH_MAP)));

  a_r5_vec_is_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && win_hit) |=> (vec_q == $past(win_idx)));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && win_hit && !EVT_MAP[win_idx] && !src_req[win_idx])
      |=> !pend_q[$past(win_idx)]);

  a_r7_evt_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && win_hit && EVT_MAP[win_idx] && src_req[win_idx])
      |=> pend_q[$past(win_idx)]);

  a_r10_order_held: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> $stable(spread_q));

  a_r11_err_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !win_hit) |=> (vec_q == ERR_VEC));

  a_r12_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & RSV_MAP) == '0) && ((mask_q & RSV_MAP) == '0));

endmodule

bind irq_vector_ctrl ivc_checker #(.RSV_MAP(RSV_MAP), .EVT_MAP(EVT_MAP)) u_chk (.*);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // {src pattern, mask, spread, expected vector}
  localparam int NV = 12;
  localparam logic [69:0] VEC_TAB [NV] = '{
    {32'h0000_0006, 32'hFFFF_FFFF, 1'b0, 5'd1},
    {32'h0000_0007, 32'hFFFF_FFFF, 1'b1, 5'd1},
    {32'h0000_0005, 32'hFFFF_FFFF, 1'b1, 5'd0},
    {32'h0000_0024, 32'hFFFF_FFFF, 1'b1, 5'd5},
    {32'h0000_0024, 32'hFFFF_FFFF, 1'b0, 5'd2},
    {32'h0000_4004, 32'hFFFF_FFFF, 1'b1, 5'd2},
    {32'h0000_2004, 32'hFFFF_FFFF, 1'b1, 5'd2},
    {32'h0000_2008, 32'hFFFF_FFFF, 1'b1, 5'd13},
    {32'h0000_2008, 32'hFFFF_FFFF, 1'b0, 5'd3},
    {32'h4000_0008, 32'hFFFF_FFFF, 1'b1, 5'd3},
    {32'h0000_0003, 32'hFFFF_FFFE, 1'b0, 5'd1},
    {32'h0000_0A00, 32'hFFFF_FDFF, 1'b0, 5'd11}
  };

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle_clear();
    src_req = '0;
    tick(1);
    wr(2'd1, 32'hFFFF_FFFF);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 pend", d, 0);
    rd(2'd2, d); check("R1 mask", d, 0);
    rd(2'd3, d); check("R1 vec", d, 0);
    check("R1 irq", {31'b0, irq_o}, 0);

    // Vector table walk: R4, R5, R8, R9
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {30'b0, VEC_TAB[i][5], 1'b1});
      wr(2'd2, VEC_TAB[i][37:6]);
      src_req = VEC_TAB[i][69:38];
      tick(2);
      check("R4 irq raised", {31'b0, irq_o}, 1);
      wr(2'd3, 32'h1);
      rd(2'd3, d);
      check(VEC_TAB[i][5] ? "R9 spread vector" : "R8 grouped vector", d, {27'b0, VEC_TAB[i][4:0]});
      idle_clear();
      tick(1);
      check("R4 irq idle", {31'b0, irq_o}, 0);
    end

    // R2 enable gating
    wr(2'd0, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    src_req = 32'h0000_0020;
    tick(1); src_req = '0; tick(1);
    check("R2 irq gated", {31'b0, irq_o}, 0);
    rd(2'd1, d); check("R3 latched after drop", d, 32'h0000_0020);
    wr(2'd0, 32'h1);
    tick(1);
    check("R2 irq enabled", {31'b0, irq_o}, 1);

    // R6 ack clears latching source, next one wins
    src_req = 32'h0000_0080; tick(1); src_req = '0;
    wr(2'd3, 32'h1);
    rd(2'd3, d); check("R5 vec 5", d, 5);
    rd(2'd1, d); check("R6 bit5 cleared", d, 32'h0000_0080);
    wr(2'd3, 32'h1);
    rd(2'd3, d); check("R5 vec 7", d, 7);
    rd(2'd1, d); check("R6 empty", d, 0);

    // R11 error vector
    wr(2'd3, 32'h1);
    rd(2'd3, d); check("R11 err vec", d, 31);

    // R7 event-register source
    src_req = 32'h0000_0002;
    tick(1);
    wr(2'd3, 32'h1);
    rd(2'd3, d); check("R7 vec 1", d, 1);
    rd(2'd1, d); check("R7 kept after ack", d, 32'h0000_0002);
    wr(2'd1, 32'h0000_0002);
    rd(2'd1, d); check("R7 kept after w1c", d, 32'h0000_0002);
    src_req = '0; tick(1);
    rd(2'd1, d); check("R7 follows level", d, 0);

    // R13 software clear
    src_req = 32'h0000_0300; tick(1); src_req = '0;
    wr(2'd1, 32'h0000_0100);
    rd(2'd1, d); check("R13 w1c one bit", d, 32'h0000_0200);
    src_req = 32'h0000_0200;
    wr(2'd1, 32'h0000_0200);
    src_req = '0;
    rd(2'd1, d); check("R13 set wins", d, 32'h0000_0200);
    wr(2'd1, 32'h0000_0200);
    rd(2'd1, d); check("R13 cleared", d, 0);

    // R12 reserved positions
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); check("R12 mask rsv", d, 32'h7F7B_EFEF);
    src_req = 32'h8084_1010; tick(2); src_req = '0;
    rd(2'd1, d); check("R12 pend rsv", d, 0);
    check("R12 no irq", {31'b0, irq_o}, 0);

    // R10 order change held while pending
    wr(2'd0, 32'h1); tick(1);
    src_req = 32'h0000_0024; tick(1);
    src_req = 32'h0000_0004;
    wr(2'd0, 32'h3);
    wr(2'd3, 32'h1);
    rd(2'd3, d); check("R10 order held", d, 2);
    idle_clear();
    tick(2);
    src_req = 32'h0000_0024; tick(2);
    wr(2'd3, 32'h1);
    rd(2'd3, d); check("R10 order taken up", d, 5);
    idle_clear();

    // R1 reset again clears state
    src_req = 32'h0000_0040; tick(1); src_req = '0;
    rst_n = 1'b0; tick(1); rst_n = 1'b1; tick(1);
    rd(2'd1, d); check("R1 pend after reset", d, 0);
    check("R1 irq after reset", {31'b0, irq_o}, 0);

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule